// File: doc/BRIEF.md
# Two-Wire Bus Dual-Address Slave Responder

This block is the target side of a two-wire serial bus controller. Whenever it is enabled it watches the clock and data lines for a start condition and shifts in the first byte of the transaction. The upper seven bits of that byte are the address and the lowest bit is the direction. The address is compared against two programmable own addresses, each with its own enable, and against the all-zero general call address when that match is enabled. On a hit the responder pulls the data line low for the acknowledge slot. It records which comparison hit and the direction, and raises a new-match flag so software can tell the first byte of a transaction from the data bytes that follow.

After the acknowledge slot of every byte the responder holds the clock line low until software services the data register, either by reading the received byte or by writing the next byte to transmit. It also flags start or stop conditions that land inside a byte or an acknowledge slot as bus errors. When the surrounding controller is acting as master and reports a line conflict, the responder records the error and pulses a lost-master indication, while address matching carries on unaffected.

Top module: `twoWireSlaveResponder`

## Requirements
- R1: Own address 1 is matched only while `ownAddr1En` is 1; with the enable low, that address is not acknowledged and `match1` stays 0.
- R2: Own address 2 is matched only while `ownAddr2En` is 1. It is independent of address 1, even when the two addresses differ only in their lowest bit.
- R3: Address 0x00 (general call) is matched only while `genCallEn` is 1, and that match is reported on `gcMatch`.
- R4: On a match the responder drives the data line low in the acknowledge slot of the first byte and sets `newMatch`. It sets `xmit` to the first byte's bit 0, where 1 means the master reads and the responder transmits. The first byte is sent MSB first.
- R5: `bufEmpty` is set when a read-direction match is latched and after each transmitted byte that the master acknowledges. A write to the data register while the clock is held clears it.
- R6: `irq` is 1 only while `newMatch`, `intEn` and `matchIntEn` are all 1.
- R7: A `clearNewMatch` pulse clears `newMatch` and leaves the match flags unchanged.
- R8: After the acknowledge slot of every byte (address or data), `sclHoldLow` stays 1 until a `dataRd` or `dataWr` pulse. A received byte appears on `rxData`, MSB first.
- R9: In transmit, the written byte is sent MSB first. A master acknowledge (data low) leads to another clock hold. A master non-acknowledge releases both lines until the next start or stop.
- R10: A start or stop condition inside a byte (after its first bit) or inside an acknowledge slot sets `busError` and clears all match flags. `clearBusError` clears `busError`.
- R11: A stop condition at a byte boundary clears the match flags without setting `busError`.
- R12: A non-matching address is not acknowledged, and the bytes after it are ignored (no acknowledge, no clock hold) until the next start.
- R13: Address matching works the same while `masterActive` is 1. A `busConflict` while `masterActive` is 1 sets `busError` and gives a one-cycle `masterLost` pulse on the following cycle.
- R14: While `enable` is 0, one cycle after it falls both line drives are released and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Responder enable |
| masterActive | input | 1 | The controller is currently bus master |
| busConflict | input | 1 | Line conflict reported by the master side |
| sclIn | input | 1 | Synchronized clock line level |
| sdaIn | input | 1 | Synchronized data line level |
| sclHoldLow | output | 1 | Pull the clock line low (stretch) |
| sdaHoldLow | output | 1 | Pull the data line low |
| ownAddr1 | input | 7 | Own address 1 |
| ownAddr1En | input | 1 | Enable match on own address 1 |
| ownAddr2 | input | 7 | Own address 2 |
| ownAddr2En | input | 1 | Enable match on own address 2 |
| genCallEn | input | 1 | Enable general call match |
| intEn | input | 1 | Global interrupt enable |
| matchIntEn | input | 1 | New-match interrupt enable |
| dataRd | input | 1 | Software read pulse of the data register |
| dataWr | input | 1 | Software write pulse of the data register |
| wrData | input | 8 | Byte written by software |
| rxData | output | 8 | Last received byte |
| clearNewMatch | input | 1 | Clear the new-match flag |
| clearBusError | input | 1 | Clear the bus-error flag |
| match1 | output | 1 | Own address 1 matched |
| match2 | output | 1 | Own address 2 matched |
| gcMatch | output | 1 | General call matched |
| newMatch | output | 1 | First byte of a transaction matched, not yet serviced |
| xmit | output | 1 | Responder transmits (master reads) |
| bufEmpty | output | 1 | Transmit byte needed |
| busError | output | 1 | Illegal condition or conflict seen |
| masterLost | output | 1 | One-cycle pulse: mastership lost on conflict |
| irq | output | 1 | New-match interrupt |

## Verification
The bench builds the block with its default byte width of 8, which gives 7-bit addresses and is the only width that matches real bus devices. With that width, the all-zero general call and two own addresses that differ only in their lowest bit can both be tested, so a comparison that ignores one bit or confuses the two registers becomes visible. The bench's bus model stretches each clock quarter over four system cycles, so the edge detection, a start or stop placed inside a byte, and the release of each hold all fall in cycles that the bench can observe.

// File: rtl/twsPkg.sv
package twsPkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_ACK,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK,
    PH_HOLD,
    PH_IGNORE
  } phase_t;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic captureRx;
    logic latchMatch;
    logic clearMatch;
    logic setError;
    logic setBufEmpty;
  } dpStrobe_t;

endpackage

// File: rtl/twsDatapath.sv
module twsDatapath
  import twsPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sdaIn,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-2:0] ownAddr1,
  input  logic              ownAddr1En,
  input  logic [DATA_W-2:0] ownAddr2,
  input  logic              ownAddr2En,
  input  logic              genCallEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              clearNewMatch,
  input  logic              clearBusError,
  input  logic              masterActive,
  input  logic              busConflict,
  output logic              anyHit,
  output logic              txBit,
  output logic [DATA_W-1:0] rxData,
  output logic              match1,
  output logic              match2,
  output logic              gcMatch,
  output logic              newMatch,
  output logic              xmit,
  output logic              bufEmpty,
  output logic              busError,
  output logic              masterLost
);

  localparam int ADDR_W  = DATA_W - 1;
  localparam int NUM_OWN = 2;

  logic [DATA_W-1:0]              rxShift;
  logic [DATA_W-1:0]              txShift;
  logic [NUM_OWN-1:0][ADDR_W-1:0] ownAddr;
  logic [NUM_OWN-1:0]             ownEn;
  logic [NUM_OWN-1:0]             ownHit;
  logic                           gcHit;
  logic                           conflictNow;

  assign ownAddr = {ownAddr2, ownAddr1};
  assign ownEn   = {ownAddr2En, ownAddr1En};

  for (genvar g = 0; g < NUM_OWN; g++) begin : gOwnCmp
    assign ownHit[g] = ownEn[g] && (rxShift[DATA_W-1:1] == ownAddr[g]);
  end

  assign gcHit       = genCallEn && (rxShift[DATA_W-1:1] == '0);
  assign anyHit      = |ownHit || gcHit;
  assign txBit       = txShift[DATA_W-1];
  assign conflictNow = masterActive && busConflict;

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      rxShift <= '0;
      txShift <= '1;
      rxData  <= '0;
    end else begin
      if (stb.shiftIn)   rxShift <= {rxShift[DATA_W-2:0], sdaIn};
      if (stb.captureRx) rxData  <= rxShift;
      if (stb.loadTx)         txShift <= wrData;
      else if (stb.shiftOut)  txShift <= {txShift[DATA_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      match1     <= 1'b0;
      match2     <= 1'b0;
      gcMatch    <= 1'b0;
      newMatch   <= 1'b0;
      xmit       <= 1'b0;
      bufEmpty   <= 1'b0;
      busError   <= 1'b0;
      masterLost <= 1'b0;
    end else begin
      masterLost <= conflictNow;
      if (stb.clearMatch) begin
        match1   <= 1'b0;
        match2   <= 1'b0;
        gcMatch  <= 1'b0;
        newMatch <= 1'b0;
        xmit     <= 1'b0;
        bufEmpty <= 1'b0;
      end else if (stb.latchMatch) begin
        match1   <= ownHit[0];
        match2   <= ownHit[1];
        gcMatch  <= gcHit;
        newMatch <= 1'b1;
        xmit     <= rxShift[0];
        bufEmpty <= rxShift[0];
      end else begin
        if (clearNewMatch)        newMatch <= 1'b0;
        if (stb.setBufEmpty)      bufEmpty <= 1'b1;
        else if (stb.loadTx)      bufEmpty <= 1'b0;
      end
      if (stb.setError || conflictNow) busError <= 1'b1;
      else if (clearBusError)          busError <= 1'b0;
    end
  end

endmodule

// File: rtl/twsControl.sv
module twsControl
  import twsPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      anyHit,
  input  logic      txBit,
  input  logic      xmit,
  input  logic      dataRd,
  input  logic      dataWr,
  output dpStrobe_t stb,
  output logic      sclHoldLow,
  output logic      sdaHoldLow
);

  localparam int               CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  phase_t           phase, phaseNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic             sclQ, sdaQ, ackSeen;
  logic             sclRise, sclFall, startCond, stopCond;
  logic             inByte, inAck;

  assign sclRise   = sclIn && !sclQ;
  assign sclFall   = !sclIn && sclQ;
  assign startCond = sclIn && sclQ && sdaQ && !sdaIn;
  assign stopCond  = sclIn && sclQ && !sdaQ && sdaIn;
  assign inByte    = (phase inside {PH_ADDR, PH_RX, PH_TX}) && (bitCnt > ONE);
  assign inAck     = phase inside {PH_ADDR_ACK, PH_RX_ACK, PH_TX_ACK};

  always_comb begin
    phaseNext  = phase;
    bitCntNext = bitCnt;
    stb        = '0;
    if (startCond || stopCond) begin
      stb.setError   = inByte || inAck;
      stb.clearMatch = 1'b1;
      phaseNext      = startCond ? PH_ADDR : PH_IDLE;
      bitCntNext     = '0;
    end else begin
      case (phase)
        PH_ADDR: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            bitCntNext  = bitCnt + ONE;
          end else if (sclFall && bitCnt == LAST_BIT) begin
            stb.latchMatch = anyHit;
            phaseNext      = anyHit ? PH_ADDR_ACK : PH_IGNORE;
          end
        end
        PH_ADDR_ACK, PH_RX_ACK: begin
          if (sclFall) phaseNext = PH_HOLD;
        end
        PH_HOLD: begin
          if (dataRd || dataWr) begin
            stb.loadTx = dataWr && xmit;
            phaseNext  = xmit ? PH_TX : PH_RX;
            bitCntNext = '0;
          end
        end
        PH_RX: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            bitCntNext  = bitCnt + ONE;
          end else if (sclFall && bitCnt == LAST_BIT) begin
            stb.captureRx = 1'b1;
            phaseNext     = PH_RX_ACK;
          end
        end
        PH_TX: begin
          if (sclRise) begin
            bitCntNext = bitCnt + ONE;
          end else if (sclFall && bitCnt != '0) begin
            stb.shiftOut = 1'b1;
            if (bitCnt == LAST_BIT) phaseNext = PH_TX_ACK;
          end
        end
        PH_TX_ACK: begin
          if (sclFall) begin
            stb.setBufEmpty = ackSeen;
            phaseNext       = ackSeen ? PH_HOLD : PH_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
      ackSeen <= 1'b0;
    end else begin
      phase  <= phaseNext;
      bitCnt <= bitCntNext;
      sclQ   <= sclIn;
      sdaQ   <= sdaIn;
      if (phase == PH_TX_ACK && sclRise) ackSeen <= !sdaIn;
    end
  end

  assign sclHoldLow = (phase == PH_HOLD);
  assign sdaHoldLow = (phase == PH_ADDR_ACK) || (phase == PH_RX_ACK) ||
                      ((phase == PH_TX) && !txBit);

endmodule

// File: rtl/twoWireSlaveResponder.sv
module twoWireSlaveResponder
  import twsPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              masterActive,
  input  logic              busConflict,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclHoldLow,
  output logic              sdaHoldLow,
  input  logic [DATA_W-2:0] ownAddr1,
  input  logic              ownAddr1En,
  input  logic [DATA_W-2:0] ownAddr2,
  input  logic              ownAddr2En,
  input  logic              genCallEn,
  input  logic              intEn,
  input  logic              matchIntEn,
  input  logic              dataRd,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rxData,
  input  logic              clearNewMatch,
  input  logic              clearBusError,
  output logic              match1,
  output logic              match2,
  output logic              gcMatch,
  output logic              newMatch,
  output logic              xmit,
  output logic              bufEmpty,
  output logic              busError,
  output logic              masterLost,
  output logic              irq
);

  dpStrobe_t stb;
  logic      anyHit;
  logic      txBit;

  twsControl #(.DATA_W(DATA_W)) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .anyHit    (anyHit),
    .txBit     (txBit),
    .xmit      (xmit),
    .dataRd    (dataRd),
    .dataWr    (dataWr),
    .stb       (stb),
    .sclHoldLow(sclHoldLow),
    .sdaHoldLow(sdaHoldLow)
  );

  twsDatapath #(.DATA_W(DATA_W)) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .sdaIn        (sdaIn),
    .stb          (stb),
    .ownAddr1     (ownAddr1),
    .ownAddr1En   (ownAddr1En),
    .ownAddr2     (ownAddr2),
    .ownAddr2En   (ownAddr2En),
    .genCallEn    (genCallEn),
    .wrData       (wrData),
    .clearNewMatch(clearNewMatch),
    .clearBusError(clearBusError),
    .masterActive (masterActive),
    .busConflict  (busConflict),
    .anyHit       (anyHit),
    .txBit        (txBit),
    .rxData       (rxData),
    .match1       (match1),
    .match2       (match2),
    .gcMatch      (gcMatch),
    .newMatch     (newMatch),
    .xmit         (xmit),
    .bufEmpty     (bufEmpty),
    .busError     (busError),
    .masterLost   (masterLost)
  );

  assign irq = newMatch && intEn && matchIntEn;

endmodule

// File: rtl/twsChecker.sv
module twsChecker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclHoldLow,
  input logic sdaHoldLow,
  input logic dataRd,
  input logic dataWr,
  input logic ownAddr1En,
  input logic ownAddr2En,
  input logic genCallEn,
  input logic match1,
  input logic match2,
  input logic gcMatch,
  input logic xmit,
  input logic bufEmpty
);

  AST_MATCH1_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(match1) |-> $past(ownAddr1En)); // R1

  AST_MATCH2_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(match2) |-> $past(ownAddr2En)); // R2

  AST_GC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gcMatch) |-> $past(genCallEn)); // R3

  AST_EMPTY_ONLY_XMIT: assert property (@(posedge clk) disable iff (!rstN)
    bufEmpty |-> xmit); // R5

  AST_HOLD_ADDRESSED: assert property (@(posedge clk) disable iff (!rstN)
    sclHoldLow |-> (match1 || match2 || gcMatch)); // R8

  AST_HOLD_UNTIL_SW: assert property (@(posedge clk) disable iff (!rstN)
    (sclHoldLow && enable && !dataRd && !dataWr) |=> sclHoldLow); // R8

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(!enable) |-> (!sclHoldLow && !sdaHoldLow && !match1 && !match2 && !gcMatch)); // R14

endmodule

bind twoWireSlaveResponder twsChecker i_twsChecker (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .sclHoldLow(sclHoldLow),
  .sdaHoldLow(sdaHoldLow),
  .dataRd    (dataRd),
  .dataWr    (dataWr),
  .ownAddr1En(ownAddr1En),
  .ownAddr2En(ownAddr2En),
  .genCallEn (genCallEn),
  .match1    (match1),
  .match2    (match2),
  .gcMatch   (gcMatch),
  .xmit      (xmit),
  .bufEmpty  (bufEmpty)
);

// File: tb/test_twoWireSlaveResponder.sv
module test_twoWireSlaveResponder;

  localparam int DATA_W = 8;
  localparam logic [6:0] ADDR_A = 7'h2A;
  localparam logic [6:0] ADDR_B = 7'h2B;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1, masterActive = 1'b0, busConflict = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic scl, sda;
  logic sclHoldLow, sdaHoldLow;
  logic [6:0] ownAddr1 = ADDR_A, ownAddr2 = ADDR_B;
  logic ownAddr1En = 1'b1, ownAddr2En = 1'b0, genCallEn = 1'b0;
  logic intEn = 1'b1, matchIntEn = 1'b1;
  logic dataRd = 1'b0, dataWr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rxData;
  logic clearNewMatch = 1'b0, clearBusError = 1'b0;
  logic match1, match2, gcMatch, newMatch, xmit, bufEmpty, busError, masterLost, irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign scl = mScl && !sclHoldLow;
  assign sda = mSda && !sdaHoldLow;

  twoWireSlaveResponder #(.DATA_W(DATA_W)) i_twoWireSlaveResponder (
    .clk(clk), .rstN(rstN), .enable(enable), .masterActive(masterActive),
    .busConflict(busConflict), .sclIn(scl), .sdaIn(sda),
    .sclHoldLow(sclHoldLow), .sdaHoldLow(sdaHoldLow),
    .ownAddr1(ownAddr1), .ownAddr1En(ownAddr1En), .ownAddr2(ownAddr2),
    .ownAddr2En(ownAddr2En), .genCallEn(genCallEn), .intEn(intEn),
    .matchIntEn(matchIntEn), .dataRd(dataRd), .dataWr(dataWr), .wrData(wrData),
    .rxData(rxData), .clearNewMatch(clearNewMatch), .clearBusError(clearBusError),
    .match1(match1), .match2(match2), .gcMatch(gcMatch), .newMatch(newMatch),
    .xmit(xmit), .bufEmpty(bufEmpty), .busError(busError),
    .masterLost(masterLost), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quarter();
    repeat (4) @(negedge clk);
  endtask

  task automatic busStart();
    mScl = 1'b1; mSda = 1'b1; quarter();
    mSda = 1'b0; quarter();
    mScl = 1'b0; quarter();
  endtask

  task automatic busStop();
    mSda = 1'b0; quarter();
    mScl = 1'b1; quarter();
    mSda = 1'b1; quarter();
  endtask

  task automatic clockBit(input logic b, output logic seen);
    mSda = b; quarter();
    mScl = 1'b1;
    while (!scl) @(negedge clk);
    quarter();
    seen = sda;
    quarter();
    mScl = 1'b0; quarter();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ackLow);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(v[i], s);
    clockBit(1'b1, s);
    ackLow = !s;
  endtask

  task automatic readByte(output logic [7:0] v, input logic masterAck);
    logic s;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, s);
      v = {v[6:0], s};
    end
    clockBit(!masterAck, s);
  endtask

  task automatic swRead();
    @(negedge clk); dataRd = 1'b1;
    @(negedge clk); dataRd = 1'b0;
  endtask

  task automatic swWrite(input logic [7:0] v);
    @(negedge clk); dataWr = 1'b1; wrData = v;
    @(negedge clk); dataWr = 1'b0;
  endtask

  task automatic pulseClearNm();
    @(negedge clk); clearNewMatch = 1'b1;
    @(negedge clk); clearNewMatch = 1'b0;
  endtask

  task automatic pulseClearErr();
    @(negedge clk); clearBusError = 1'b1;
    @(negedge clk); clearBusError = 1'b0;
  endtask

  task automatic tReset();
    check("R14 reset match1", match1, 0);
    check("R14 reset busError", busError, 0);
    check("R14 reset line drives", {sclHoldLow, sdaHoldLow}, 0);
  endtask

  task automatic tWriteAddr1();
    logic a;
    busStart();
    sendByte({ADDR_A, 1'b0}, a);
    check("R4 address ack", a, 1);
    check("R1 match1 set", match1, 1);
    check("R2 match2 clear", match2, 0);
    check("R4 newMatch", newMatch, 1);
    check("R4 xmit write", xmit, 0);
    check("R6 irq both enables", irq, 1);
    check("R8 hold after address", sclHoldLow, 1);
    swRead();
    check("R8 release after read", sclHoldLow, 0);
    sendByte(8'hA5, a);
    check("R8 data ack", a, 1);
    check("R8 rxData", rxData, 8'hA5);
    check("R8 hold after data", sclHoldLow, 1);
    pulseClearNm();
    check("R7 newMatch cleared", newMatch, 0);
    check("R7 match1 kept", match1, 1);
    check("R6 irq off", irq, 0);
    swRead();
    busStop();
    check("R11 stop clears match", match1, 0);
    check("R11 no error", busError, 0);
  endtask

  task automatic tAddr2();
    logic a;
    ownAddr2En = 1'b0;
    busStart();
    sendByte({ADDR_B, 1'b0}, a);
    check("R2 disabled nack", a, 0);
    check("R2 disabled no flag", match2, 0);
    sendByte({ADDR_A, 1'b0}, a);
    check("R12 ignored byte nack", a, 0);
    check("R12 ignored no hold", sclHoldLow, 0);
    check("R12 ignored no match", match1, 0);
    busStop();
    ownAddr2En = 1'b1;
    busStart();
    sendByte({ADDR_B, 1'b0}, a);
    check("R2 enabled ack", a, 1);
    check("R2 match2 set", match2, 1);
    check("R2 match1 not set", match1, 0);
    swRead();
    busStop();
    ownAddr2En = 1'b0;
    ownAddr1En = 1'b0;
    busStart();
    sendByte({ADDR_A, 1'b0}, a);
    check("R1 disabled nack", a, 0);
    check("R1 disabled no flag", match1, 0);
    busStop();
    ownAddr1En = 1'b1;
  endtask

  task automatic tGenCall();
    logic a;
    genCallEn = 1'b0;
    busStart();
    sendByte(8'h00, a);
    check("R3 gc disabled nack", a, 0);
    check("R3 gc disabled flag", gcMatch, 0);
    busStop();
    genCallEn = 1'b1;
    matchIntEn = 1'b0;
    busStart();
    sendByte(8'h00, a);
    check("R3 gc ack", a, 1);
    check("R3 gcMatch", gcMatch, 1);
    check("R6 irq gated by matchIntEn", irq, 0);
    swRead();
    busStop();
    genCallEn = 1'b0;
    matchIntEn = 1'b1;
  endtask

  task automatic tRead();
    logic a;
    logic [7:0] v;
    busStart();
    sendByte({ADDR_A, 1'b1}, a);
    check("R4 read address ack", a, 1);
    check("R4 xmit read", xmit, 1);
    check("R5 bufEmpty on read match", bufEmpty, 1);
    swWrite(8'h3C);
    check("R5 bufEmpty cleared by write", bufEmpty, 0);
    readByte(v, 1'b1);
    check("R9 first tx byte", v, 8'h3C);
    check("R9 hold after master ack", sclHoldLow, 1);
    check("R5 bufEmpty after master ack", bufEmpty, 1);
    swWrite(8'h81);
    readByte(v, 1'b0);
    check("R9 second tx byte", v, 8'h81);
    check("R9 no hold after nack", sclHoldLow, 0);
    check("R9 data released after nack", sdaHoldLow, 0);
    busStop();
    check("R11 stop after read", match1, 0);
  endtask

  task automatic tIllegal();
    logic a, s;
    busStart();
    sendByte({ADDR_A, 1'b0}, a);
    swRead();
    for (int i = 0; i < 3; i++) clockBit(1'b0, s);
    busStop();
    check("R10 busError on mid-byte stop", busError, 1);
    check("R10 match cleared", match1, 0);
    pulseClearErr();
    check("R10 busError cleared", busError, 0);
  endtask

  task automatic tMaster();
    logic a;
    masterActive = 1'b1;
    busStart();
    sendByte({ADDR_A, 1'b0}, a);
    check("R13 ack while master", a, 1);
    check("R13 match while master", match1, 1);
    @(negedge clk); busConflict = 1'b1;
    @(negedge clk); busConflict = 1'b0;
    check("R13 masterLost pulse", masterLost, 1);
    check("R13 busError on conflict", busError, 1);
    @(negedge clk);
    check("R13 masterLost one cycle", masterLost, 0);
    check("R13 match survives conflict", match1, 1);
    masterActive = 1'b0;
    swRead();
    busStop();
    pulseClearErr();
  endtask

  task automatic tDisable();
    logic a;
    busStart();
    sendByte({ADDR_A, 1'b0}, a);
    check("R14 held before disable", sclHoldLow, 1);
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check("R14 disabled no hold", sclHoldLow, 0);
    check("R14 disabled flags", {match1, newMatch}, 0);
    enable = 1'b1;
    busStop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tWriteAddr1();
    tAddr2();
    tGenCall();
    tRead();
    tIllegal();
    tMaster();
    tDisable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule